// File: doc/BRIEF.md
# GPIO Falling-Edge Event Trigger

This block watches a bank of general-purpose input pins and produces a one-clock event pulse for each pin that falls while falling-edge detection is armed for it. Each pulse is meant to drive both an interrupt line and a DMA request for that pin. Each pin passes through a multi-flop synchronizer. The edge detector compares consecutive synchronized samples. The arm bits live in a hidden trigger mask.

Software never writes the mask directly. The register bus has two alias addresses. A write to the arm alias sets every mask bit whose data bit is 1. A write to the disarm alias clears every mask bit whose data bit is 1. Data bits that are 0 leave their mask bits alone. A read of either alias returns the current mask in the low bits and zeros above it. If both aliases ever target the same bit in one cycle, the disarm wins.

Top module: `gpio_fall_trig`

## Requirements
- R1: After synchronous reset, every mask bit is 0, no event is raised, and reading either alias returns 0.
- R2: When mask bit n is 1 and pin n falls from 1 to 0, `fall_evt[n]` is high for exactly one clock. With two synchronizer stages it rises after the third rising clock edge that samples the new low level.
- R3: A falling edge on a pin whose mask bit is 0 raises no event.
- R4: A rising edge or a steady level on a pin raises no event, whatever its mask bit.
- R5: A write to the arm alias (byte offset 0x10) sets mask bit n for each data bit n (n < 16) that is 1. Data bits that are 0 leave their mask bits unchanged.
- R6: A write to the disarm alias (byte offset 0x14) clears mask bit n for each data bit n (n < 16) that is 1. Data bits that are 0 leave their mask bits unchanged.
- R7: Reading either alias returns the mask in bits 15:0 and 0 in bits 31:16, in the same cycle. Reading any other address returns 0.
- R8: Data bits 31:16 of any write are ignored, and writes to addresses other than the two aliases leave the mask unchanged.
- R9: The mask bit is sampled in the cycle the detected edge would be reported. An edge reported after its bit is cleared is suppressed. An edge already past when its bit is set is never reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | Asynchronous pin levels |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fall_evt | output | 16 | Per-pin event pulses |

## Verification
The bench builds the block with its defaults: 16 pins, two synchronizer stages, an 8-bit byte address and a 32-bit data bus. With these values the whole 16-bit mask can be armed and disarmed pattern by pattern. The 16 unused upper data bits let the bench show that those bits are ignored on writes and read back as zero. The short three-cycle pin-to-event latency lets a small history window in the bench predict every pulse while random pins and random alias writes change the mask between edges.

// File: rtl/gpio_fall_trig_pkg.sv
package gpio_fall_trig_pkg;

    localparam int GFT_PINS_DEF   = 16;
    localparam int GFT_DATA_W_DEF = 32;
    localparam int GFT_ADDR_W_DEF = 8;
    localparam int GFT_SYNC_DEF   = 2;
    localparam logic [7:0] GFT_ARM_OFS_DEF    = 8'h10;
    localparam logic [7:0] GFT_DISARM_OFS_DEF = 8'h14;

    typedef enum logic [1:0] {
        GFT_SEL_NONE   = 2'd0,
        GFT_SEL_ARM    = 2'd1,
        GFT_SEL_DISARM = 2'd2
    } gft_sel_e;

    typedef struct packed {
        logic arm_we;
        logic disarm_we;
    } gft_wr_s;

    function automatic gft_sel_e gft_decode(input logic [7:0] addr,
                                            input logic [7:0] arm_ofs,
                                            input logic [7:0] disarm_ofs);
        if (addr == arm_ofs)         return GFT_SEL_ARM;
        else if (addr == disarm_ofs) return GFT_SEL_DISARM;
        else                         return GFT_SEL_NONE;
    endfunction

endpackage

// File: rtl/gft_sync.sv
module gft_sync #(
    parameter int NUM_PINS = 16,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_sync
);
    logic [NUM_PINS-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= pin_raw;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign pin_sync = stg[STAGES-1];
endmodule

// File: rtl/gft_mask_regs.sv
module gft_mask_regs
    import gpio_fall_trig_pkg::*;
#(
    parameter int          NUM_PINS   = 16,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  ARM_OFS    = 8'h10,
    parameter logic [7:0]  DISARM_OFS = 8'h14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] trig_mask
);
    localparam int PAD_W = DATA_W - NUM_PINS;

    gft_sel_e            sel;
    gft_wr_s             wr;
    logic [NUM_PINS-1:0] arm_bits;
    logic [NUM_PINS-1:0] disarm_bits;
    logic [NUM_PINS-1:0] mask_q;
    logic [7:0]          addr8;

    assign addr8 = 8'(bus_addr);

    always_comb begin
        sel          = gft_decode(addr8, ARM_OFS, DISARM_OFS);
        wr.arm_we    = bus_wr && (sel == GFT_SEL_ARM);
        wr.disarm_we = bus_wr && (sel == GFT_SEL_DISARM);
        arm_bits     = wr.arm_we    ? bus_wdata[NUM_PINS-1:0] : '0;
        disarm_bits  = wr.disarm_we ? bus_wdata[NUM_PINS-1:0] : '0;
    end

    // disarm overrides arm on the same bit
    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | arm_bits) & ~disarm_bits;
    end

    always_comb begin
        if (sel != GFT_SEL_NONE) bus_rdata = {{PAD_W{1'b0}}, mask_q};
        else                     bus_rdata = '0;
    end

    assign trig_mask = mask_q;
endmodule

// File: rtl/gft_edge_det.sv
module gft_edge_det #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] trig_mask,
    output logic [NUM_PINS-1:0] fall_evt
);
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] evt_q;
    logic [NUM_PINS-1:0] fell;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        assign fell[n] = prev_q[n] & ~pin_sync[n] & trig_mask[n];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            evt_q  <= '0;
        end else begin
            prev_q <= pin_sync;
            evt_q  <= fell;
        end
    end

    assign fall_evt = evt_q;
endmodule

// File: rtl/gpio_fall_trig.sv
module gpio_fall_trig
    import gpio_fall_trig_pkg::*;
#(
    parameter int         NUM_PINS    = GFT_PINS_DEF,
    parameter int         DATA_W      = GFT_DATA_W_DEF,
    parameter int         ADDR_W      = GFT_ADDR_W_DEF,
    parameter int         SYNC_STAGES = GFT_SYNC_DEF,
    parameter logic [7:0] ARM_OFS     = GFT_ARM_OFS_DEF,
    parameter logic [7:0] DISARM_OFS  = GFT_DISARM_OFS_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] fall_evt
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] trig_mask;

    gft_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_raw(pin_in), .pin_sync(pin_sync)
    );

    gft_mask_regs #(
        .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .ARM_OFS(ARM_OFS), .DISARM_OFS(DISARM_OFS)
    ) u_mask (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_mask(trig_mask)
    );

    gft_edge_det #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst(rst), .pin_sync(pin_sync),
        .trig_mask(trig_mask), .fall_evt(fall_evt)
    );
endmodule

// File: rtl/gft_checker.sv
module gft_checker #(
    parameter int         NUM_PINS   = 16,
    parameter int         DATA_W     = 32,
    parameter int         ADDR_W     = 8,
    parameter logic [7:0] ARM_OFS    = 8'h10,
    parameter logic [7:0] DISARM_OFS = 8'h14
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] fall_evt,
    input logic [NUM_PINS-1:0] trig_mask
);
    logic is_arm, is_disarm;
    assign is_arm    = (8'(bus_addr) == ARM_OFS);
    assign is_disarm = (8'(bus_addr) == DISARM_OFS);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (trig_mask == '0 && fall_evt == '0));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|fall_evt) |=> ((fall_evt & $past(fall_evt)) == '0));

    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (fall_evt & ~$past(trig_mask)) == '0);

    a_r5_arm_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_arm) |=>
        ((trig_mask & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    a_r6_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && is_disarm) |=>
        ((trig_mask & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    a_r7_readback: assert property (@(posedge clk) disable iff (rst)
        (is_arm || is_disarm) |-> (bus_rdata == DATA_W'(trig_mask)));

    a_r8_other_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!(bus_wr && (is_arm || is_disarm))) |=> $stable(trig_mask));
endmodule

bind gpio_fall_trig gft_checker #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ARM_OFS(ARM_OFS), .DISARM_OFS(DISARM_OFS)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fall_evt(fall_evt),
    .trig_mask(trig_mask)
);

// File: tb/gpio_fall_trig_tb.sv
`timescale 1ns/1ps
module gpio_fall_trig_tb;
    localparam int NP = 16;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [7:0] ARM = 8'h10;
    localparam logic [7:0] DIS = 8'h14;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_in;
    logic [AW-1:0] bus_addr;
    logic          bus_wr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] fall_evt;

    always #2.5 clk = ~clk;

    gpio_fall_trig u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fall_evt(fall_evt)
    );

    int errs = 0;
    int checks = 0;
    logic [NP-1:0] mdl_mask = '0;
    logic [NP-1:0] h1 = '0, h2 = '0, h3 = '0, h4 = '0;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [NP-1:0] m);
        if (a == ARM || a == DIS) return DW'(m);
        return '0;
    endfunction

    // drive at negedge, check read, clock once, check events
    task automatic step(input logic [NP-1:0] pins, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input string etag, input string rtag);
        logic [NP-1:0] mprev;
        pin_in = pins; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        chk(rtag, bus_rdata, exp_read(a, mdl_mask));
        @(posedge clk);
        mprev = mdl_mask;
        if (wr && a == ARM) mdl_mask = mdl_mask | wd[NP-1:0];
        if (wr && a == DIS) mdl_mask = mdl_mask & ~wd[NP-1:0];
        h4 = h3; h3 = h2; h2 = h1; h1 = pins;
        @(negedge clk);
        chk(etag, DW'(fall_evt), DW'(h4 & ~h3 & mprev));
    endtask

    task automatic idle(input logic [NP-1:0] pins, input int n, input string etag);
        for (int i = 0; i < n; i++) step(pins, 1'b0, 8'h00, '0, etag, "R7 other-addr read");
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; pin_in = '0; bus_wr = 1'b0; bus_addr = ARM; bus_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset event", DW'(fall_evt), '0);
        chk("R1 reset readback", bus_rdata, '0);

        // R5 and R8: arm with junk in the upper half
        step('0, 1'b1, ARM, 32'hFFFF_0005, "R1 idle", "R1 read arm alias");
        step('0, 1'b0, DIS, '0, "R4 idle", "R7 disarm alias read");
        chk("R5 arm", DW'(mdl_mask), 32'h5);
        step('0, 1'b0, ARM, '0, "R4 idle", "R8 upper bits read zero");
        step('0, 1'b1, DIS, 32'h0000_0000, "R4 idle", "R6 zero write");
        step('0, 1'b0, DIS, '0, "R4 idle", "R6 zero write no effect");
        step('0, 1'b1, 8'h18, 32'hFFFF_FFFF, "R4 idle", "R7 other-addr read");
        step('0, 1'b0, ARM, '0, "R4 idle", "R8 other-addr write no effect");
        step('0, 1'b1, ARM, 32'h0, "R4 idle", "R5 zero write");
        step('0, 1'b0, ARM, '0, "R4 idle", "R5 zero write no effect");

        // R4: rising edges, then R2/R3: pin0 armed, pin1 not
        idle(16'hFFFF, 5, "R4 rising edge");
        idle(16'hFFFC, 6, "R2 R3 fall pin0 armed pin1 masked");
        idle(16'hFFFF, 5, "R4 rising edge");

        // R9: disarm pin0 before its edge
        step(16'hFFFF, 1'b1, DIS, 32'h1, "R4 idle", "R6 disarm read");
        step(16'hFFFF, 1'b0, DIS, '0, "R4 idle", "R6 disarm readback");
        idle(16'hFFFE, 5, "R9 cleared before edge");
        // R9: pin3 falls while unarmed, armed later
        idle(16'hFFF6, 6, "R3 unarmed fall");
        step(16'hFFF6, 1'b1, ARM, 32'h8, "R9 stale edge", "R5 arm read");
        idle(16'hFFF6, 6, "R9 stale edge not reported");
        idle(16'hFFFE, 5, "R4 rising edge");
        idle(16'hFFF6, 6, "R2 fall pin3 armed");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [NP-1:0] p;
            logic w;
            logic [AW-1:0] a;
            int r;
            p = NP'($urandom);
            w = ($urandom % 6) == 0;
            r = $urandom % 4;
            a = (r == 0) ? ARM : (r == 1) ? DIS : (r == 2) ? 8'(($urandom % 64) * 4) : ARM;
            step(p, w, a, $urandom, "R2 R3 R4 R9 random events", "R5 R6 R7 R8 random read");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule